// File: doc/BRIEF.md
# Charge Pump Clock Selector

This block derives the switching clock of a charge-pump stage from a 2 MHz reference. Each pump rate is a binary division of that reference: half the reference rate, a quarter, an eighth or a sixteenth. Lower rates suit light load, where they cut the reactive power lost in the pump. A converter enable and a latched fault input gate the whole block. While the converter is off, or a fault is present, the pump clock and its clock-enable are held low and the divider is cleared.

After enable rises, the pump always starts at the fastest rate (1 MHz). The select pins play no part during this phase. The sequencer raises a soft-start-done flag within 10 ms of enable. On the first cycle that flag is seen, the block captures the select pins and from then on runs at the captured rate. The select pins are read at no other time. A new rate takes effect only once a full low phase has completed, so every half-period the output ever shows belongs entirely to one rate.

Top module: `cp_clk_sel`

## Requirements
- R1: While `en_i` is low or `fault_i` is high, `cp_clk_o` and `cp_en_o` are low from the next reference edge on. Reset also forces both low.
- R2: At the first reference edge with `en_i` high and `fault_i` low, both `cp_en_o` and `cp_clk_o` go high.
- R3: Until soft-start-done has been captured, each high and each low phase of `cp_clk_o` lasts exactly one reference cycle (1 MHz from 2 MHz), whatever `sel_i` holds.
- R4: Rate encoding, with `sel_i[0]` as the first select pin and `sel_i[1]` as the second. A value of 2'b00 gives half-periods of 1 reference cycle (1 MHz). 2'b01 gives 2 cycles (500 kHz), 2'b10 gives 4 cycles (250 kHz) and 2'b11 gives 8 cycles (125 kHz).
- R5: `sel_i` is captured on the first cycle in which `ss_done_i` is high while the block is enabled. Later changes of `sel_i`, and later pulses of `ss_done_i`, have no effect until the block is disabled and enabled again.
- R6: A rate change takes effect only at the end of a complete low phase. Every phase length seen while enabled is one of the legal half-periods, never a truncated one.
- R7: Every low phase lasts exactly as long as the high phase just before it (50% duty cycle).
- R8: After a disable or a fault, the next enable starts again at the fastest rate and captures the select pins afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 2 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable, active high |
| fault_i | input | 1 | Latched protection fault, active high |
| ss_done_i | input | 1 | Soft start finished, from the sequencer |
| sel_i | input | 2 | Rate select; bit 0 = first select pin, bit 1 = second |
| cp_clk_o | output | 1 | Charge-pump switching clock |
| cp_en_o | output | 1 | Charge-pump clock enable |

## Verification
The hardest case is a rate change while the divider is mid-period. It is the only point where a truncated phase could appear, and it occurs only once per enable, after soft start. The stimulus sets the slowest select value, enables the block, and raises `ss_done_i` a few cycles later. It then records every phase over several periods of the transition and checks each length and each high/low pairing. A second sequence disables or faults the block and re-enables it with other select values. This shows that the earlier capture does not survive and that a late change of the select pins is ignored.

// File: rtl/cp_clk_pkg.sv
package cp_clk_pkg;
  localparam int unsigned SEL_W_DEF = 2;
endpackage

// File: rtl/cp_sel_latch.sv
module cp_sel_latch #(
  parameter int unsigned SEL_W = cp_clk_pkg::SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             ss_done_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] target_o
);
  logic             ss_seen_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_seen_q <= 1'b0;
      sel_q     <= '0;
    end else if (!active_i) begin
      ss_seen_q <= 1'b0;
      sel_q     <= '0;
    end else if (ss_done_i && !ss_seen_q) begin
      ss_seen_q <= 1'b1;
      sel_q     <= sel_i;
    end
  end

  // fastest rate until soft start is over
  assign target_o = ss_seen_q ? sel_q : '0;
endmodule

// File: rtl/cp_half_div.sv
module cp_half_div #(
  parameter int unsigned SEL_W = cp_clk_pkg::SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [SEL_W-1:0] target_i,
  output logic             clk_o
);
  localparam int unsigned NUM_RATES = 1 << SEL_W;
  localparam int unsigned CNT_W     = (NUM_RATES > 1) ? NUM_RATES - 1 : 1;

  logic [CNT_W-1:0] tc_tbl [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tc
    assign tc_tbl[g] = CNT_W'((64'd1 << g) - 64'd1);
  end

  logic [SEL_W-1:0] rate_q;
  logic [CNT_W-1:0] hcnt_q;
  logic             clk_q;
  logic             at_tc;

  assign at_tc = (hcnt_q == tc_tbl[rate_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      hcnt_q <= '0;
      clk_q  <= 1'b0;
    end else if (!active_i) begin
      rate_q <= '0;
      hcnt_q <= '0;
      clk_q  <= 1'b0;
    end else if (at_tc) begin
      hcnt_q <= '0;
      clk_q  <= ~clk_q;
      // new rate only at the end of a full low phase
      if (!clk_q) rate_q <= target_i;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign clk_o = clk_q;
endmodule

// File: rtl/cp_clk_sel.sv
module cp_clk_sel #(
  parameter int unsigned SEL_W = cp_clk_pkg::SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fault_i,
  input  logic             ss_done_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             cp_clk_o,
  output logic             cp_en_o
);
  logic             active;
  logic [SEL_W-1:0] target;
  logic             en_q;

  assign active = en_i & ~fault_i;

  cp_sel_latch #(.SEL_W(SEL_W)) i_sel_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .ss_done_i (ss_done_i),
    .sel_i     (sel_i),
    .target_o  (target)
  );

  cp_half_div #(.SEL_W(SEL_W)) i_half_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .target_i (target),
    .clk_o    (cp_clk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= active;
  end

  assign cp_en_o = en_q;
endmodule

// File: rtl/cp_clk_sel_chk.sv
module cp_clk_sel_chk #(
  parameter int unsigned SEL_W = cp_clk_pkg::SEL_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             fault_i,
  input logic             ss_done_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             cp_clk_o,
  input logic             cp_en_o
);
  localparam int unsigned MAX_HALF = 1 << ((1 << SEL_W) - 1);

  logic        past_valid, ss_seen, clk_d, hi_valid;
  logic [15:0] hi_cnt, lo_cnt, last_hi;
  logic        fall, rise;

  assign fall = past_valid && clk_d && !cp_clk_o && cp_en_o;
  assign rise = past_valid && !clk_d && cp_clk_o && cp_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_valid <= 1'b0;
      ss_seen    <= 1'b0;
      clk_d      <= 1'b0;
      hi_valid   <= 1'b0;
      hi_cnt     <= '0;
      lo_cnt     <= '0;
      last_hi    <= '0;
    end else begin
      past_valid <= 1'b1;
      clk_d      <= cp_clk_o;
      if (!(en_i && !fault_i)) ss_seen <= 1'b0;
      else if (ss_done_i)      ss_seen <= 1'b1;
      hi_cnt <= cp_clk_o ? hi_cnt + 16'd1 : 16'd0;
      lo_cnt <= cp_clk_o ? 16'd0 : lo_cnt + 16'd1;
      if (!cp_en_o) hi_valid <= 1'b0;
      else if (fall) begin
        hi_valid <= 1'b1;
        last_hi  <= hi_cnt;
      end
    end
  end

  assert_off_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid && !$past(en_i && !fault_i) |-> !cp_clk_o && !cp_en_o);

  assert_en_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid && $past(en_i && !fault_i) |-> cp_en_o);

  assert_fast_before_ss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall && !ss_seen |-> hi_cnt == 16'd1);

  assert_legal_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |-> $onehot(hi_cnt) && hi_cnt <= 16'(MAX_HALF));

  assert_duty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && hi_valid |-> lo_cnt == last_hi);
endmodule

bind cp_clk_sel cp_clk_sel_chk #(.SEL_W(SEL_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .fault_i   (fault_i),
  .ss_done_i (ss_done_i),
  .sel_i     (sel_i),
  .cp_clk_o  (cp_clk_o),
  .cp_en_o   (cp_en_o)
);

// File: tb/test_cp_clk_sel.sv
module test_cp_clk_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, fault = 1'b0, ss = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       cp_clk, cp_en;
  int         total = 0, bad = 0;

  always #2.5 clk = ~clk;

  cp_clk_sel i_cp_clk_sel (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fault_i(fault),
    .ss_done_i(ss), .sel_i(sel), .cp_clk_o(cp_clk), .cp_en_o(cp_en)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic get_period(output int hi, output int lo);
    hi = 0; lo = 0;
    @(negedge clk);
    while (cp_clk) @(negedge clk);
    while (!cp_clk) @(negedge clk);
    while (cp_clk) begin hi++; @(negedge clk); end
    while (!cp_clk) begin lo++; @(negedge clk); end
  endtask

  task automatic restart(logic [1:0] s);
    en = 1'b0; ss = 1'b0;
    wait_cyc(3);
    sel = s; en = 1'b1;
    wait_cyc(6);
    ss = 1'b1;
    wait_cyc(40);
  endtask

  task automatic t_reset();
    check("R1 reset clk", int'(cp_clk), 0);
    check("R1 reset en", int'(cp_en), 0);
    rst_n = 1'b1;
    wait_cyc(5);
    check("R1 idle clk", int'(cp_clk), 0);
    check("R1 idle en", int'(cp_en), 0);
  endtask

  task automatic t_start();
    int hi, lo;
    sel = 2'b11; en = 1'b1;
    @(negedge clk);
    check("R2 en rises", int'(cp_en), 1);
    check("R2 clk rises", int'(cp_clk), 1);
    for (int k = 0; k < 3; k++) begin
      get_period(hi, lo);
      check("R3 high before ss", hi, 1);
      check("R3 low before ss", lo, 1);
    end
  endtask

  task automatic t_rates();
    int hi, lo;
    for (int s = 0; s < 4; s++) begin
      restart(2'(s));
      get_period(hi, lo);
      check("R4 high half", hi, 1 << s);
      check("R7 low half", lo, 1 << s);
    end
  endtask

  task automatic t_hold();
    int hi, lo;
    restart(2'b10);
    sel = 2'b00;
    get_period(hi, lo);
    check("R5 sel change ignored", hi, 4);
    sel = 2'b01; ss = 1'b0;
    wait_cyc(3);
    ss = 1'b1;
    wait_cyc(20);
    get_period(hi, lo);
    check("R5 ss repulse ignored", hi, 4);
  endtask

  task automatic t_switch();
    logic smp [80];
    int   runs [80];
    logic lvl [80];
    int   n, ok;
    en = 1'b0; ss = 1'b0;
    wait_cyc(3);
    sel = 2'b11; en = 1'b1;
    wait_cyc(5);
    ss = 1'b1;
    for (int i = 0; i < 80; i++) begin smp[i] = cp_clk; @(negedge clk); end
    n = 0; runs[0] = 1; lvl[0] = smp[0];
    for (int i = 1; i < 80; i++) begin
      if (smp[i] == smp[i-1]) runs[n]++;
      else begin n++; runs[n] = 1; lvl[n] = smp[i]; end
    end
    ok = 1;
    for (int k = 1; k < n; k++)
      if (runs[k] != 1 && runs[k] != 8) ok = 0;
    check("R6 no truncated phase", ok, 1);
    ok = 1;
    for (int k = 1; k + 1 < n; k++)
      if (lvl[k] && runs[k+1] != runs[k]) ok = 0;
    check("R7 low equals high", ok, 1);
    check("R6 reached slow rate", runs[n-1] == 8 || runs[n-2] == 8 ? 1 : 0, 1);
  endtask

  task automatic t_fault();
    int hi, lo;
    restart(2'b11);
    fault = 1'b1; ss = 1'b0;
    @(negedge clk);
    check("R1 fault clk", int'(cp_clk), 0);
    check("R1 fault en", int'(cp_en), 0);
    wait_cyc(4);
    sel = 2'b01; fault = 1'b0;
    get_period(hi, lo);
    check("R8 fast after fault", hi, 1);
    ss = 1'b1;
    wait_cyc(20);
    get_period(hi, lo);
    check("R8 new select", hi, 2);
    en = 1'b0;
    @(negedge clk);
    check("R1 disable clk", int'(cp_clk), 0);
    check("R1 disable en", int'(cp_en), 0);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    t_reset();
    t_start();
    t_rates();
    t_hold();
    t_switch();
    t_fault();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule